// File: doc/BRIEF.md
# Byte-Serial Register Command Deserializer

This block sits on an 8-bit byte-serial command bus and turns each framed command into one register write. A command opens with a strobe that marks its first byte. The remaining bytes follow on consecutive clock cycles. The first two bytes form a 16-bit address, low byte first. The data bytes come after the address, least significant byte first. The number of bytes in a command is set at elaboration time.

The assembled address is compared with a base address on the bit positions that a mask selects. A matching command produces three outputs: a single-cycle write enable, the assembled data word, and a local register address. The local address is made of the address bits that the mask leaves free. Several instances can share one bus, each with its own base and mask, so that each one claims only its own small register window.

Top module: `cmd_deserializer`

## Requirements
- R1: A strobe loads the current byte as byte 0 of a new command. Each following cycle loads the next byte. Bytes 0 and 1 form address[7:0] and address[15:8]. When a command's byte NUM_BYTES-1 arrives in cycle t and the command matches, `wr_en` is high in cycle t+1 only.
- R2: A command matches when (address XOR BASE_ADDR) AND ADDR_MASK is zero. Address bits where the mask is 0 have no effect on the match. A command that does not match leaves `wr_en` low and leaves `wr_addr` and `wr_data` unchanged.
- R3: Bit k of `wr_addr` is the address bit at the k-th position, counting up from bit 0, where ADDR_MASK is 0. With the default mask 0x07FE, `wr_addr[0]` is address bit 0.
- R4: Byte 2 of a command goes to `wr_data[7:0]`, byte 3 to `wr_data[15:8]`, and so on. Bits at DATA_W and above are dropped, so with the defaults `wr_data` is {byte3[2:0], byte2}.
- R5: Data bits that no received byte supplies read as zero. For example, with NUM_BYTES=3 and DATA_W=12, `wr_data[11:8]` is 0.
- R6: A strobe that arrives before the current command is complete discards the partial command. Its byte becomes byte 0 of a new command.
- R7: Bytes that arrive while no command is open, with no strobe, are ignored: they cause no write and change no output.
- R8: While `rst` is high at a clock edge, the byte counter, `wr_en`, `wr_addr` and `wr_data` are cleared. A command that reset cuts short never produces a write.
- R9: `wr_addr` and `wr_data` change only in a cycle where `wr_en` is high. They keep their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_byte | input | 8 | Byte lane of the command bus |
| bus_stb | input | 1 | High with the first byte of a command |
| wr_en | output | 1 | One-cycle write enable for a matching command |
| wr_addr | output | LADDR_W | Local register address from the free address bits |
| wr_data | output | DATA_W | Assembled data word |

## Verification
The byte counter and its open-command flag are the only hidden state. If either goes wrong, the error reaches the ports within one command length. A counter that is off by one moves the write pulse one cycle early or late, or shifts the data bytes by one lane. A flag that stays set makes loose bus bytes complete a phantom command, and the phantom shows up as an unexpected `wr_en`. Mixing aborted commands, idle bytes and reset in the middle of a command with clean commands exposes each of these faults within a few cycles of the stimulus that provokes it.

// File: rtl/cmdds_pkg.sv
package cmdds_pkg;

    localparam int LANE_W      = 8;
    localparam int FULL_ADDR_W = 16;
    localparam int MAX_DATA_W  = 32;
    localparam int ADDR_BYTES  = FULL_ADDR_W / LANE_W;

    typedef logic [LANE_W-1:0]      lane_t;
    typedef logic [FULL_ADDR_W-1:0] full_addr_t;
    typedef logic [MAX_DATA_W-1:0]  wide_data_t;

    // One fully assembled command, before decoding.
    typedef struct packed {
        full_addr_t addr;
        wide_data_t data;
    } cmd_frame_t;

    // Collects the address bits at the positions where the mask is 0 and
    // packs them downward from bit 0 of the result.
    function automatic full_addr_t pack_free_bits(input full_addr_t a, input full_addr_t m);
        full_addr_t r;
        logic [4:0] k;
        r = '0;
        k = '0;
        for (int i = 0; i < FULL_ADDR_W; i++) begin
            if (!m[i]) begin
                r[k[3:0]] = a[i];
                k = k + 5'd1;
            end
        end
        return r;
    endfunction

    function automatic logic window_hit(input full_addr_t a, input full_addr_t base,
                                        input full_addr_t m);
        return ((a ^ base) & m) == '0;
    endfunction

endpackage

// File: rtl/cmdds_collect.sv
module cmdds_collect
    import cmdds_pkg::*;
#(
    parameter int NUM_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  lane_t      in_byte,
    input  logic       in_stb,
    output logic       frame_done,
    output cmd_frame_t frame
);
    localparam int IDX_W  = $clog2(NUM_BYTES);
    localparam int HELD   = NUM_BYTES - 1;
    localparam int DBYTES = NUM_BYTES - ADDR_BYTES;

    logic [IDX_W-1:0]       cnt_q;
    logic                   busy_q;
    logic [HELD*LANE_W-1:0] held_q;
    logic [IDX_W-1:0]       idx;
    logic                   accept;
    logic                   last;
    logic [NUM_BYTES*LANE_W-1:0] all_bytes;

    // A strobe always restarts at slot 0, whatever the counter holds.
    assign idx        = in_stb ? '0 : cnt_q;
    assign accept     = in_stb | busy_q;
    assign last       = (idx == IDX_W'(NUM_BYTES - 1));
    assign frame_done = accept & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (accept) begin
            if (last) begin
                cnt_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                cnt_q  <= idx + IDX_W'(1);
                busy_q <= 1'b1;
            end
        end
    end

    // Byte slots for every position except the last one, which is used
    // straight from the bus in the cycle it arrives.
    always_ff @(posedge clk) begin
        for (int g = 0; g < HELD; g++) begin
            if (accept && idx == IDX_W'(g)) begin
                held_q[g*LANE_W +: LANE_W] <= in_byte;
            end
        end
    end

    assign all_bytes = {in_byte, held_q};

    always_comb begin
        frame.addr = all_bytes[FULL_ADDR_W-1:0];
        frame.data = '0;
        for (int j = 0; j < DBYTES; j++) begin
            frame.data[j*LANE_W +: LANE_W] = all_bytes[(ADDR_BYTES+j)*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/cmdds_decode.sv
module cmdds_decode
    import cmdds_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0728,
    parameter logic [15:0] ADDR_MASK = 16'h07FE,
    parameter int          LADDR_W   = 1,
    parameter int          DATA_W    = 11
) (
    input  cmd_frame_t         frame,
    output logic               hit,
    output logic [LADDR_W-1:0] local_addr,
    output logic [DATA_W-1:0]  local_data
);
    full_addr_t packed_free;

    assign hit         = window_hit(frame.addr, BASE_ADDR, ADDR_MASK);
    assign packed_free = pack_free_bits(frame.addr, ADDR_MASK);
    assign local_addr  = packed_free[LADDR_W-1:0];
    assign local_data  = frame.data[DATA_W-1:0];

    generate
        if (LADDR_W < FULL_ADDR_W) begin : g_addr_spare
            logic unused_addr_bits;
            assign unused_addr_bits = ^packed_free[FULL_ADDR_W-1:LADDR_W];
        end
        if (DATA_W < MAX_DATA_W) begin : g_data_spare
            logic unused_data_bits;
            assign unused_data_bits = ^frame.data[MAX_DATA_W-1:DATA_W];
        end
    endgenerate

endmodule

// File: rtl/cmd_deserializer.sv
module cmd_deserializer
    import cmdds_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0728,
    parameter logic [15:0] ADDR_MASK = 16'h07FE,
    parameter int          NUM_BYTES = 4,   // 3..6: two address bytes plus 1..4 data bytes
    parameter int          LADDR_W   = 1,
    parameter int          DATA_W    = 11   // at most 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         bus_byte,
    input  logic               bus_stb,
    output logic               wr_en,
    output logic [LADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data
);
    cmd_frame_t         frame;
    logic               frame_done;
    logic               hit;
    logic [LADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0]  dec_data;
    logic               fire;

    cmdds_collect #(
        .NUM_BYTES(NUM_BYTES)
    ) collect_i (
        .clk       (clk),
        .rst       (rst),
        .in_byte   (bus_byte),
        .in_stb    (bus_stb),
        .frame_done(frame_done),
        .frame     (frame)
    );

    cmdds_decode #(
        .BASE_ADDR(BASE_ADDR),
        .ADDR_MASK(ADDR_MASK),
        .LADDR_W  (LADDR_W),
        .DATA_W   (DATA_W)
    ) decode_i (
        .frame     (frame),
        .hit       (hit),
        .local_addr(dec_addr),
        .local_data(dec_data)
    );

    assign fire = frame_done & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) begin
                wr_addr <= dec_addr;
                wr_data <= dec_data;
            end
        end
    end

endmodule

// File: rtl/cmdds_checker.sv
module cmdds_checker #(
    parameter int NUM_BYTES = 4,
    parameter int LADDR_W   = 1,
    parameter int DATA_W    = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_stb,
    input logic               wr_en,
    input logic [LADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]  wr_data
);
    // A write pulse lasts one cycle only.
    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // A write pulse comes NUM_BYTES cycles after the strobe that opened the command.
    assert_strobe_lead_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(bus_stb, NUM_BYTES));

    // A strobe on what would have been the last byte starts over, so it never completes a command.
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(bus_stb));

    // Reset clears the pulse and both output words.
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!wr_en && wr_addr == '0 && wr_data == '0));

    // The outputs hold their values except in a write cycle.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

bind cmd_deserializer cmdds_checker #(
    .NUM_BYTES(NUM_BYTES),
    .LADDR_W  (LADDR_W),
    .DATA_W   (DATA_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .bus_stb(bus_stb),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
);

// File: tb/cmd_deserializer_tb_top.sv
module cmd_deserializer_tb_top;

    localparam logic [15:0] BASE = 16'h0728;
    localparam logic [15:0] MASK = 16'h07FE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_byte = 8'h00;
    logic       bus_stb = 1'b0;

    logic        we0, we1;
    logic [0:0]  addr0, addr1;
    logic [10:0] data0;
    logic [11:0] data1;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    cmd_deserializer #(
        .BASE_ADDR(BASE), .ADDR_MASK(MASK), .NUM_BYTES(4), .LADDR_W(1), .DATA_W(11)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_byte(bus_byte), .bus_stb(bus_stb),
        .wr_en(we0), .wr_addr(addr0), .wr_data(data0)
    );

    cmd_deserializer #(
        .BASE_ADDR(BASE), .ADDR_MASK(MASK), .NUM_BYTES(3), .LADDR_W(1), .DATA_W(12)
    ) dut_short_i (
        .clk(clk), .rst(rst), .bus_byte(bus_byte), .bus_stb(bus_stb),
        .wr_en(we1), .wr_addr(addr1), .wr_data(data1)
    );

    // Reference model, one slot per instance
    int         cfg_n [2] = '{4, 3};
    int         cfg_dw[2] = '{11, 12};
    logic       m_open[2];
    int         m_cnt [2];
    logic [7:0] m_b   [2][6];
    logic       e_we  [2];
    logic [15:0] e_addr[2];
    logic [31:0] e_data[2];

    function automatic logic [15:0] free_bits(input logic [15:0] a, input logic [15:0] m);
        logic [15:0] r = '0;
        int k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i] == 1'b0) begin
                r[k] = a[i];
                k++;
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_open[d] = 0; m_cnt[d] = 0;
            e_we[d] = 0; e_addr[d] = '0; e_data[d] = '0;
        end
    endtask

    task automatic model_step(input logic s, input logic [7:0] b);
        for (int d = 0; d < 2; d++) begin
            e_we[d] = 0;
            if (s) begin m_open[d] = 1; m_cnt[d] = 0; end
            if (m_open[d]) begin
                m_b[d][m_cnt[d]] = b;
                m_cnt[d]++;
                if (m_cnt[d] == cfg_n[d]) begin
                    logic [15:0] a;
                    logic [31:0] dv;
                    m_open[d] = 0;
                    a  = {m_b[d][1], m_b[d][0]};
                    dv = '0;
                    for (int j = 0; j < cfg_n[d] - 2; j++) dv[8*j +: 8] = m_b[d][2+j];
                    dv = dv & ((32'd1 << cfg_dw[d]) - 32'd1);
                    if (((a ^ BASE) & MASK) == 16'h0) begin
                        e_we[d]   = 1;
                        e_addr[d] = {15'd0, free_bits(a, MASK)[0]};
                        e_data[d] = dv;
                    end
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        logic        aw [2];
        logic [15:0] aa [2];
        logic [31:0] ad [2];
        aw[0] = we0; aa[0] = {15'd0, addr0}; ad[0] = {21'd0, data0};
        aw[1] = we1; aa[1] = {15'd0, addr1}; ad[1] = {20'd0, data1};
        for (int d = 0; d < 2; d++) begin
            vectors++;
            if (aw[d] !== e_we[d] || aa[d] !== e_addr[d] || ad[d] !== e_data[d]) begin
                fails++;
                $display("FAIL %s inst%0d: got we=%0b addr=%h data=%h, expected we=%0b addr=%h data=%h",
                         tag, d, aw[d], aa[d], ad[d], e_we[d], e_addr[d], e_data[d]);
            end
        end
    endtask

    // One bus cycle: check what the previous cycle produced, then drive.
    task automatic step(input logic s, input logic [7:0] b, input logic r, input string tag);
        @(negedge clk);
        compare(tag);
        bus_stb  = s;
        bus_byte = b;
        rst      = r;
        if (r) model_reset();
        else   model_step(s, b);
    endtask

    task automatic send(input logic [15:0] a, input logic [31:0] dv, input int nb, input string tag);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] by;
            by = (i == 0) ? a[7:0] : (i == 1) ? a[15:8] : dv[8*(i-2) +: 8];
            step(i == 0, by, 1'b0, tag);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        // R8: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, "R8 reset");
        idle(2, "R8 reset");

        send(16'h0728, 32'h0000_05A3, 4, "R1 R4"); idle(2, "R1 R4");
        send(16'h0729, 32'h0000_FFFF, 4, "R3 R4"); idle(2, "R3 R4");
        send(16'h0728, 32'h0000_00C3, 4, "R3 R9"); idle(3, "R9 hold");
        send(16'h072A, 32'h0000_0123, 4, "R2 miss"); idle(2, "R2 miss");
        send(16'h0628, 32'h0000_0456, 4, "R2 miss"); idle(2, "R2 miss");
        send(16'hF729, 32'h0000_0789, 4, "R2 free bits"); idle(2, "R2 free bits");
        send(16'h0728, 32'h0000_00AB, 3, "R5 short"); idle(2, "R5 short");

        // R7: loose bytes with no strobe
        step(1'b0, 8'h28, 1'b0, "R7 idle");
        step(1'b0, 8'h07, 1'b0, "R7 idle");
        step(1'b0, 8'h11, 1'b0, "R7 idle");
        step(1'b0, 8'h22, 1'b0, "R7 idle");
        idle(2, "R7 idle");

        // R6: restart in the middle of a command
        step(1'b1, 8'h28, 1'b0, "R6 restart");
        step(1'b0, 8'h07, 1'b0, "R6 restart");
        step(1'b1, 8'h29, 1'b0, "R6 restart");
        step(1'b0, 8'h07, 1'b0, "R6 restart");
        step(1'b0, 8'h34, 1'b0, "R6 restart");
        step(1'b0, 8'h02, 1'b0, "R6 restart");
        idle(2, "R6 restart");

        // R8: reset cuts a command short
        step(1'b1, 8'h28, 1'b0, "R8 cut");
        step(1'b0, 8'h07, 1'b0, "R8 cut");
        step(1'b0, 8'h11, 1'b1, "R8 cut");
        step(1'b0, 8'h22, 1'b0, "R8 cut");
        idle(3, "R8 cut");

        // R1: back-to-back commands
        send(16'h0729, 32'h0000_0321, 4, "R1 back-to-back");
        send(16'h0728, 32'h0000_0654, 4, "R1 back-to-back");
        idle(2, "R1 back-to-back");

        // Random mix
        for (int n = 0; n < 500; n++) begin
            logic [15:0] a;
            int sel, nb, gap;
            sel = $urandom % 4;
            case (sel)
                0: a = 16'h0728;
                1: a = 16'h0729;
                2: a = 16'($urandom);
                default: a = {5'($urandom), 11'h728 | 11'($urandom % 2)};
            endcase
            nb  = 1 + ($urandom % 5);
            send(a, $urandom, nb, "R1 R2 R6 random");
            gap = $urandom % 3;
            for (int g = 0; g < gap; g++) step(1'b0, 8'($urandom), 1'b0, "R7 R9 random");
        end
        idle(3, "R9 final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule